// File: doc/BRIEF.md
# Gated Radiation Pulse Totalizer

This block counts pulses from several radiation detectors, one channel per detector. The pulse inputs have no timing relation to the core clock. Each channel brings its input into the clock domain and turns every rising edge into a single-cycle strobe. It adds up those strobes over an acquisition window. The window length is set in units of a 0.1-second tick, which a shared prescaler derives from the system clock. When a window closes, the channel writes its total into a private queue, clears its counter and opens the next window at once. The channels work in parallel, and each has its own window timer, counter and queue.

A processor drives the block through a small memory-mapped slave port that never stalls. It writes command words to start a channel, stop it, set its window length or flush its queue. It reads a status word and pops totals from one data address per channel. Read data comes back one cycle after the read strobe.

Top module: `pulse_totalizer`

## Requirements
- R1: After reset every channel is stopped and its queue is empty with no overflow. The status word reads 0x11 for two channels, and the data reads return 0.
- R2: Each rising edge on a pulse input adds exactly one to its channel's total. A level that stays high for many cycles counts once.
- R3: Pulses that arrive while a channel is stopped change neither its count nor its queue.
- R4: While a channel runs, a total is queued each time N ticks have passed since its window opened, where N is the programmed length. The counter then restarts from zero in a new window, so a window with no pulses queues 0.
- R5: A command is a write to address 0. Bits [3:0] select the channel index, bits [7:4] hold the opcode (1 start, 2 stop, 3 set length, 4 flush queue) and bits [31:16] hold the length in ticks.
- R6: Stop halts the channel and drops its partial count. No total is queued while the channel is stopped.
- R7: Channels count concurrently and independently. Each total lands only in its own channel's queue.
- R8: A read of address 2+c pops one total from channel c, and the value appears on rdata in the next cycle. A read of an empty queue returns 0 and changes nothing.
- R9: A read of address 1 returns status with 4 bits per channel c at [4c+3:4c]: bit 0 empty, bit 1 full, bit 2 overflow, bit 3 running.
- R10: A total that arrives while the queue is full is dropped and sets that channel's overflow flag. The flag stays set until a flush command for that channel.
- R11: Flush empties the channel's queue and clears its overflow flag. If a total closes in the same cycle as a flush, the flush wins.
- R12: A strobe in the cycle that closes a window counts in the closing total, so the totals over consecutive windows add up to exactly the pulses sent.
- R13: A command whose channel index or opcode is out of range has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | NUM_CH | Asynchronous detector pulses, one per channel |
| addr | input | ADDR_W | Word address of the slave port |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data (command word) |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after rd |

## Verification
Two functions can land in the same clock cycle: a strobe arrives in the very cycle a window closes, and a total is pushed into a queue while the processor pops or flushes it. The bench sends a long train of pulses, evenly spaced, across several short windows while it keeps polling status. This sweeps strobes over every window boundary. The bench then judges the result by conservation: the totals drained from the queue must add up to the exact number of pulses sent. An overflow run fills a queue to full and then checks the sticky flag, the surviving entries and the effect of a flush.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_START   = 4'd1,
    OP_STOP    = 4'd2,
    OP_SETTIME = 4'd3,
    OP_FLUSH   = 4'd4
  } pt_op_e;

  localparam int CMD_ADDR   = 0;
  localparam int STAT_ADDR  = 1;
  localparam int DATA_BASE  = 2;
  localparam int STAT_BITS  = 4;
  localparam int ST_EMPTY   = 0;
  localparam int ST_FULL    = 1;
  localparam int ST_OVF     = 2;
  localparam int ST_RUN     = 3;
  localparam int TIME_W     = 16;

  typedef struct packed {
    logic              start;
    logic              stop;
    logic              settime;
    logic              flush;
    logic [TIME_W-1:0] ticks;
  } pt_cmd_t;
endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int DIV = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pt_pulse_sync.sv
module pt_pulse_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic strobe_o
);
  // two capture stages, then one history stage for edge detection
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      strobe_o <= 1'b0;
    end else begin
      sh_q     <= {sh_q[1:0], pin_async};
      strobe_o <= sh_q[1] & ~sh_q[2];
    end
  end
endmodule

// File: rtl/pt_fifo.sv
module pt_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] q,
  output logic         pop_ok,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, rptr_q;
  logic         push_ok;

  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  // storage and output register kept free of reset so block RAM fits
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) q <= mem[rptr_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/pt_channel.sv
module pt_channel
  import pt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DEPTH     = 16,
  parameter int DEF_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pin_async,
  input  pt_cmd_t          cmd,
  input  logic             pop,
  output logic [CNT_W-1:0] q,
  output logic             pop_ok,
  output logic             empty,
  output logic             full,
  output logic             ovf,
  output logic             running,
  output logic             push,
  output logic             strobe
);
  logic              open_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TIME_W-1:0] len_q, left_q;
  logic              close;
  logic              cnt_max;
  logic [CNT_W-1:0]  total;

  pt_pulse_sync u_sync (
    .clk(clk), .rst(rst), .pin_async(pin_async), .strobe_o(strobe)
  );

  assign cnt_max = &cnt_q;
  assign close   = running && open_q && tick && (left_q == TIME_W'(1))
                   && !cmd.start && !cmd.stop;
  // a strobe in the closing cycle belongs to the closing window
  assign total   = (strobe && !cnt_max) ? cnt_q + 1'b1 : cnt_q;
  assign push    = close;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      open_q  <= 1'b0;
      cnt_q   <= '0;
      left_q  <= '0;
      len_q   <= TIME_W'(DEF_TICKS);
      ovf     <= 1'b0;
    end else begin
      if (cmd.settime && cmd.ticks != '0) len_q <= cmd.ticks;

      if (cmd.flush)          ovf <= 1'b0;
      else if (close && full) ovf <= 1'b1;

      if (cmd.start) begin
        running <= 1'b1;
        open_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (cmd.stop) begin
        running <= 1'b0;
        open_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (running) begin
        if (!open_q) begin
          if (tick) begin
            open_q <= 1'b1;
            left_q <= len_q;
          end
        end else if (close) begin
          cnt_q  <= '0;
          left_q <= len_q;
        end else begin
          if (tick) left_q <= left_q - 1'b1;
          if (strobe && !cnt_max) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  pt_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(cmd.flush), .push(close), .din(total),
    .pop(pop), .q(q), .pop_ok(pop_ok), .empty(empty), .full(full)
  );
endmodule

// File: rtl/pulse_totalizer.sv
module pulse_totalizer
  import pt_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int TICK_DIV   = 10_000_000,
  parameter int DEF_TICKS  = 10,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pulse_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              rd,
  output logic [31:0]       rdata
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ST_W  = NUM_CH * STAT_BITS;

  logic              tick;
  logic              cmd_hit;
  logic [3:0]        cmd_sel;
  pt_op_e            cmd_op;
  logic [NUM_CH-1:0] ch_empty, ch_full, ch_ovf, ch_run, ch_push, ch_strobe;
  logic [NUM_CH-1:0] ch_pop, ch_pop_ok;
  logic [CNT_W-1:0]  ch_q [NUM_CH];
  logic [31:0]       stat_vec;
  logic [31:0]       stat_q;
  logic              rd_stat_q, rd_data_q;
  logic [CH_W-1:0]   rd_ch_q, rd_ch_d;
  logic [CNT_W-1:0]  sel_q;

  pt_prescaler #(.DIV(TICK_DIV)) u_presc (.clk(clk), .rst(rst), .tick_o(tick));

  assign cmd_hit = wr && (addr == ADDR_W'(CMD_ADDR));
  assign cmd_sel = wdata[3:0];
  assign cmd_op  = pt_op_e'(wdata[7:4]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pt_cmd_t cmd;
    logic    match;
    assign match       = cmd_hit && (cmd_sel == 4'(c));
    assign cmd.start   = match && (cmd_op == OP_START);
    assign cmd.stop    = match && (cmd_op == OP_STOP);
    assign cmd.settime = match && (cmd_op == OP_SETTIME);
    assign cmd.flush   = match && (cmd_op == OP_FLUSH);
    assign cmd.ticks   = wdata[31:16];
    assign ch_pop[c]   = rd && (addr == ADDR_W'(DATA_BASE + c));

    pt_channel #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .DEF_TICKS(DEF_TICKS)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .pin_async(pulse_in[c]), .cmd(cmd),
      .pop(ch_pop[c]), .q(ch_q[c]), .pop_ok(ch_pop_ok[c]), .empty(ch_empty[c]),
      .full(ch_full[c]), .ovf(ch_ovf[c]), .running(ch_run[c]),
      .push(ch_push[c]), .strobe(ch_strobe[c])
    );

    assign stat_vec[c*STAT_BITS + ST_EMPTY] = ch_empty[c];
    assign stat_vec[c*STAT_BITS + ST_FULL]  = ch_full[c];
    assign stat_vec[c*STAT_BITS + ST_OVF]   = ch_ovf[c];
    assign stat_vec[c*STAT_BITS + ST_RUN]   = ch_run[c];
  end

  if (ST_W < 32) begin : g_pad
    assign stat_vec[31:ST_W] = '0;
  end

  always_comb begin
    rd_ch_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_pop[c]) rd_ch_d = CH_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      rd_stat_q <= 1'b0;
      rd_data_q <= 1'b0;
      rd_ch_q   <= '0;
    end else begin
      rd_stat_q <= rd && (addr == ADDR_W'(STAT_ADDR));
      rd_data_q <= |ch_pop_ok;
      rd_ch_q   <= rd_ch_d;
      if (rd && (addr == ADDR_W'(STAT_ADDR))) stat_q <= stat_vec;
    end
  end

  assign sel_q = ch_q[rd_ch_q];

  always_comb begin
    rdata = '0;
    if (rd_stat_q)      rdata = stat_q;
    else if (rd_data_q) rdata = 32'(sel_q);
  end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic [31:0]       wdata,
  input logic              rd,
  input logic [31:0]       rdata,
  input logic [NUM_CH-1:0] ch_empty,
  input logic [NUM_CH-1:0] ch_full,
  input logic [NUM_CH-1:0] ch_ovf,
  input logic [NUM_CH-1:0] ch_run,
  input logic [NUM_CH-1:0] ch_push,
  input logic [NUM_CH-1:0] ch_strobe
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> rdata == 32'd0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
      ch_strobe[c] |=> !ch_strobe[c]);

    assert_no_push_stopped_R6: assert property (@(posedge clk) disable iff (rst)
      !ch_run[c] |-> !ch_push[c]);

    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (rd && addr == ADDR_W'(2 + c) && ch_empty[c]) |=> rdata == 32'd0);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
      !(ch_empty[c] && ch_full[c]));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      (ch_ovf[c] && !(wr && addr == '0 && wdata[7:4] == 4'd4 && wdata[3:0] == 4'(c)))
      |=> ch_ovf[c]);

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == '0 && wdata[7:4] == 4'd4 && wdata[3:0] == 4'(c))
      |=> (ch_empty[c] && !ch_ovf[c]));
  end
endmodule

bind pulse_totalizer pt_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr(wr), .wdata(wdata), .rd(rd),
  .rdata(rdata), .ch_empty(ch_empty), .ch_full(ch_full), .ch_ovf(ch_ovf),
  .ch_run(ch_run), .ch_push(ch_push), .ch_strobe(ch_strobe)
);

// File: tb/pulse_totalizer_tb_top.sv
module pulse_totalizer_tb_top;
  localparam int NUM_CH = 2;
  localparam int DIV    = 50;
  localparam int DEPTH  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  pulse_in = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [35:0] exp_q [$];   // {channel, expected total}

  always #5 clk = ~clk;

  pulse_totalizer #(.NUM_CH(NUM_CH), .CNT_W(32), .FIFO_DEPTH(DEPTH),
                    .TICK_DIV(DIV), .DEF_TICKS(3), .ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .addr(addr), .wr(wr),
    .wdata(wdata), .rd(rd), .rdata(rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk); addr = 4'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic cmd(input int ch, input int op, input int ticks);
    bus_write(0, {16'(ticks), 8'h00, 4'(op), 4'(ch)});
  endtask

  task automatic pulses(input int ch, input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_in[ch] = 1'b1;
      repeat (hi) @(negedge clk);
      pulse_in[ch] = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic wait_ready(input int ch, input string req);
    logic [31:0] s;
    bit got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      bus_read(1, s);
      if (!s[ch*4]) got = 1;
    end
    if (!got) check(0, req, 1, 0);
  endtask

  // driver side of the scoreboard
  task automatic expect_total(input int ch, input int val);
    exp_q.push_back({4'(ch), 32'(val)});
  endtask

  // monitor side: pop each expected item once the design has it
  task automatic monitor(input string req);
    logic [31:0] d;
    while (exp_q.size() > 0) begin
      logic [35:0] e = exp_q.pop_front();
      wait_ready(int'(e[35:32]), req);
      bus_read(2 + int'(e[35:32]), d);
      check(d == e[31:0], req, int'(d), int'(e[31:0]));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    int sum, entries;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(1, d); check(d == 32'h11, "R1 status", int'(d), 32'h11);
    // R8 empty read
    bus_read(2, d); check(d == 0, "R8 empty read", int'(d), 0);
    bus_read(1, d); check(d == 32'h11, "R8 status after empty read", int'(d), 32'h11);

    // R3 pulses while stopped
    pulses(0, 5, 3, 3);
    repeat (20) @(negedge clk);
    bus_read(1, d); check(d == 32'h11, "R3 stopped", int'(d), 32'h11);

    // R5/R2/R4: window 6 ticks, 10 short pulses plus one long level
    cmd(0, 3, 6);
    cmd(0, 1, 0);
    bus_read(1, d); check(d[3] == 1'b1, "R5 running bit", int'(d), 32'h19);
    repeat (60) @(negedge clk);
    pulses(0, 10, 3, 3);
    pulses(0, 1, 100, 5);
    expect_total(0, 11);   // R2
    expect_total(0, 0);    // R4 idle window
    monitor("R2 R4 totals");
    cmd(0, 2, 0);          // R6 stop
    repeat (400) @(negedge clk);
    bus_read(1, d); check(d == 32'h11, "R6 no push after stop", int'(d), 32'h11);

    // R7 parallel channels
    cmd(0, 3, 4);
    cmd(1, 3, 4);
    cmd(0, 1, 0);
    cmd(1, 1, 0);
    repeat (60) @(negedge clk);
    fork
      pulses(0, 7, 2, 4);
      pulses(1, 12, 3, 5);
    join
    expect_total(0, 7);
    expect_total(1, 12);
    monitor("R7 independent totals");
    cmd(0, 2, 0); cmd(1, 2, 0);
    cmd(0, 4, 0); cmd(1, 4, 0);
    bus_read(1, d); check(d == 32'h11, "R11 flush both", int'(d), 32'h11);

    // R13 bad channel index and bad opcode
    cmd(5, 1, 0);
    cmd(0, 9, 0);
    repeat (3 * DIV) @(negedge clk);
    bus_read(1, d); check(d == 32'h11, "R13 ignored commands", int'(d), 32'h11);

    // R12 conservation across window boundaries
    cmd(1, 3, 2);
    cmd(1, 1, 0);
    repeat (60) @(negedge clk);
    pulses(1, 57, 3, 4);
    repeat (2 * DIV + 20) @(negedge clk);
    cmd(1, 2, 0);
    sum = 0; entries = 0;
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(1, d);
      if (!d[4]) begin
        bus_read(3, d); sum += int'(d); entries++;
      end
    end
    check(sum == 57, "R12 sum of totals", sum, 57);
    check(entries >= 3, "R12 windows crossed", entries, 3);

    // R10 overflow with window of one tick, nothing read
    cmd(0, 3, 1);
    cmd(0, 1, 0);
    repeat (11 * DIV + 10) @(negedge clk);
    bus_read(1, d); check(d == 32'h1E, "R10 full and overflow", int'(d), 32'h1E);
    cmd(0, 2, 0);
    for (int i = 0; i < 4; i++) begin
      bus_read(2, d); check(d == 0, "R10 stored idle total", int'(d), 0);
    end
    bus_read(1, d); check(d == 32'h14, "R10 sticky overflow", int'(d), 32'h14);
    cmd(0, 4, 0);
    bus_read(1, d); check(d == 32'h11, "R11 flush clears", int'(d), 32'h11);
    bus_read(2, d); check(d == 0, "R11 read after flush", int'(d), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule